// File: doc/BRIEF.md
# Serial Ones Counter

This block counts how many bits are set in a seven-bit word by walking through the word one bit per clock. A start pulse arms the machine. On the next clock the word is captured into a shift register and the running tally is cleared. Over the following seven clocks the least significant bit of the register is tested and the register then shifts right. The tally goes up by one each time the tested bit is 1. When the seventh bit has been tested, the machine parks in a finished state. It raises a done flag and holds the final tally until another start pulse arrives.

It suits a context where area matters more than latency and where one count in flight at a time is enough. The caller keeps the word on its input until the capture clock has passed. After that the input may change freely.

Top module: `ones_count_serial`

## Requirements
- R1: A synchronous active-low reset puts the machine in its idle state, with `count_o` at 0 and `done_o` at 0.
- R2: A clock edge that samples `start_i` high while the machine is idle starts a run: the next clock is the capture cycle. The capture edge that ends it loads `word_i` into the shift register and clears the tally to 0.
- R3: After the capture edge, exactly seven scan edges follow, one for each bit, taking bit 0 first and bit 6 last. `done_o` rises after the ninth edge counted from the edge that sampled start.
- R4: On each scan edge the tally increments if the bit under test is 1 and keeps its value if it is 0. `count_o` always shows the running tally.
- R5: When `done_o` is high, `count_o` equals the number of 1 bits in the captured word, from 0 to 7, with no wrap.
- R6: While the machine is finished and `start_i` is low, `done_o` stays high and `count_o` holds its value.
- R7: A start pulse during the capture or scan cycles has no effect on the run in progress.
- R8: A start pulse while finished begins a new run: `done_o` falls after that edge, and the tally clears at the following capture edge.
- R9: `word_i` is sampled only at the capture edge. Changes to it during the scan do not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Starts a run when idle or finished |
| word_i | input | 7 | Word whose set bits are counted |
| count_o | output | 3 | Running and then final tally of set bits |
| done_o | output | 1 | High while the final tally is held |

## Verification
The bench goes after words at the extremes. An all-zero word catches an increment that ignores the tested bit. An all-ones word exposes a counter that wraps or a scan that stops one bit short, which would report 6. Single-bit words at position 0 and at position 6 catch a scan that starts or ends at the wrong bit. The bench also changes `word_i` and pulses `start_i` in the middle of a scan. A design that re-sampled the word, or restarted on a stray start, would drift from the reference model's tally. The runs are chained from the finished state, so a machine that did not clear the tally on restart would carry the old count into the next run.

// File: rtl/ones_count_pkg.sv
// Package: shared types for the serial ones counter.
// Assumes: the four phases below are the only sequencer states.
package ones_count_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_SCAN = 2'd2,
        PH_DONE = 2'd3
    } phase_t;
endpackage

// File: rtl/ones_count_shreg.sv
// Shift register: captures a word on load and moves it right one place per
// shift, so that bit 0 always carries the bit under test.
// Assumes: load and shift are never high together.
module ones_count_shreg #(
    parameter int WORD_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              lsb_o
);
    logic [WORD_W-1:0] sr_q;

    // Capture the word on load, otherwise shift toward bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)       sr_q <= '0;
        else if (load_i)  sr_q <= word_i;
        else if (shift_i) sr_q <= sr_q >> 1;
    end

    assign lsb_o = sr_q[0];

    assert_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (sr_q == $past(word_i)));
    assert_shift_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !load_i) |=> !sr_q[WORD_W-1]);
endmodule

// File: rtl/ones_count_tally.sv
// Tally counter: clears on request and otherwise steps up by one when enabled.
// Assumes: it is enabled at most MAX_CNT times between clears.
module ones_count_tally #(
    parameter int MAX_CNT = 7,
    localparam int CNT_W  = $clog2(MAX_CNT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_q;

    // Clear has priority over increment; hold when neither is active.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else if (en_i)  cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clr_i) |-> (cnt_q < CNT_W'(MAX_CNT)));
    assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !en_i) |=> $stable(cnt_q));
endmodule

// File: rtl/ones_count_seq.sv
// Sequencer: runs idle, then one capture cycle, then WORD_W scan cycles,
// then finished. A start pulse is accepted only when idle or finished.
// Assumes: start is a level that is sampled on each clock edge.
module ones_count_seq #(
    parameter int WORD_W = 7,
    localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic shift_o,
    output logic done_o
);
    import ones_count_pkg::*;

    phase_t             ph_q, ph_d;
    logic [IDX_W-1:0]   idx_q;

    // Choose the next phase from the current phase, start and the bit index.
    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_IDLE: if (start_i) ph_d = PH_LOAD;
            PH_LOAD: ph_d = PH_SCAN;
            PH_SCAN: if (idx_q == IDX_W'(WORD_W - 1)) ph_d = PH_DONE;
            PH_DONE: if (start_i) ph_d = PH_LOAD;
            default: ph_d = PH_IDLE;
        endcase
    end

    // Register the phase.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_IDLE;
        else        ph_q <= ph_d;
    end

    // Track the bit under test: zero at capture, one step per scan cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                idx_q <= '0;
        else if (ph_q == PH_LOAD)  idx_q <= '0;
        else if (ph_q == PH_SCAN)  idx_q <= idx_q + 1'b1;
    end

    assign load_o  = (ph_q == PH_LOAD);
    assign shift_o = (ph_q == PH_SCAN);
    assign done_o  = (ph_q == PH_DONE);

    assert_one_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_o, shift_o, done_o}));
    assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((ph_q == PH_IDLE || ph_q == PH_DONE) && start_i) |=> load_o);
    assert_load_scan_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> shift_o);
    assert_done_after_scan_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(shift_o));
    assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);
    assert_scan_ignores_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_o || (shift_o && idx_q != IDX_W'(WORD_W - 1))) |=> shift_o);
endmodule

// File: rtl/ones_count_serial.sv
// Top: counts the set bits of a word serially, one bit per clock, and holds
// the result with a done flag until the next start.
// Assumes: word_i is valid on the capture clock after start is accepted.
module ones_count_serial #(
    parameter int WORD_W = 7,
    localparam int CNT_W = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              done_o
);
    logic load_w, shift_w, lsb_w;

    ones_count_seq #(.WORD_W(WORD_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load_w),
        .shift_o (shift_w),
        .done_o  (done_o)
    );

    ones_count_shreg #(.WORD_W(WORD_W)) u_shreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_w),
        .shift_i (shift_w),
        .word_i  (word_i),
        .lsb_o   (lsb_w)
    );

    ones_count_tally #(.MAX_CNT(WORD_W)) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (load_w),
        .en_i  (shift_w & lsb_w),
        .cnt_o (count_o)
    );

    assert_done_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> $stable(count_o));
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (count_o == '0 && !done_o));
endmodule

// File: tb/ones_count_serial_tb.sv
// Bench: behavioural per-clock reference model compared on every clock,
// plus targeted end-of-run checks.
module ones_count_serial_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [6:0] word_i = '0;
    logic [2:0] count_o;
    logic       done_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit cmp_en = 1'b0;

    // Reference model state: 0 idle, 1 capture, 2 scan, 3 finished.
    int         m_ph = 0;
    int         m_idx = 0;
    int         m_cnt = 0;
    logic [6:0] m_word = '0;

    ones_count_serial u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .word_i  (word_i),
        .count_o (count_o),
        .done_o  (done_o)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Advance the reference model on each rising edge, using the same inputs.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_ph = 0; m_idx = 0; m_cnt = 0; m_word = '0;
        end else begin
            case (m_ph)
                0: if (start_i) m_ph = 1;
                1: begin m_word = word_i; m_cnt = 0; m_idx = 0; m_ph = 2; end
                2: begin
                    if (m_word[0]) m_cnt = m_cnt + 1;
                    m_word = m_word >> 1;
                    if (m_idx == 6) m_ph = 3;
                    m_idx = m_idx + 1;
                end
                default: if (start_i) m_ph = 1;
            endcase
        end
    end

    // Compare on every falling edge: R4 running tally, R3 done timing.
    always @(negedge clk) begin
        if (cmp_en) begin
            check(count_o == 3'(m_cnt), "R4 running tally", int'(count_o), m_cnt);
            check(done_o == (m_ph == 3), "R3 done timing", int'(done_o), int'(m_ph == 3));
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic run_word(input logic [6:0] w, input bit disturb);
        int held;
        @(negedge clk); word_i = w; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        check(done_o == 1'b0, "R8 done falls on start", int'(done_o), 0);
        @(negedge clk);
        check(count_o == 3'd0, "R2 tally cleared at capture", int'(count_o), 0);
        if (disturb) begin
            word_i = ~w; start_i = 1'b1;          // R7 and R9 disturbances
            @(negedge clk); start_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
        check(count_o == 3'($countones(w)), "R5 final count", int'(count_o), $countones(w));
        held = int'(count_o);
        repeat (3) @(negedge clk);
        check(done_o && int'(count_o) == held, "R6 result held", int'(count_o), held);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(count_o == 3'd0 && done_o == 1'b0, "R1 reset state", int'({done_o, count_o}), 0);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        repeat (2) @(negedge clk);
        check(done_o == 1'b0, "R1 idle without start", int'(done_o), 0);
        run_word(7'b0000000, 1'b0);
        run_word(7'b1111111, 1'b0);
        run_word(7'b0000001, 1'b0);
        run_word(7'b1000000, 1'b0);
        run_word(7'b1010101, 1'b1);
        run_word(7'b0111110, 1'b1);
        for (int i = 0; i < 20; i++) run_word(7'($urandom), i[0]);
        cmp_en = 1'b0;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check(count_o == 3'd0 && done_o == 1'b0, "R1 reset from finished", int'({done_o, count_o}), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule